// File: doc/BRIEF.md
# Dual-Channel Double-Buffered DAC Loader

This block is the digital front end of a dual 12-bit multiplying converter. A host writes each channel's code a byte at a time over an 8-bit parallel bus. Two address bits and active-low select and write strobes choose one of four holding registers: a low byte and a high nibble for each of channels A and B. A separate active-low load strobe, independent of write, copies both holding codes into the two output code registers in the same cycle. Host writes can therefore prepare new codes for both channels while the output stays unchanged, and the load strobe then switches both channels together.

All three strobes come from outside the clock domain. Each passes through a two-flop synchroniser, and all state changes happen on the block's own clock. As a digital stand-in for the multiplying analog stage, each channel drives a signed 16-bit value equal to the negated reference sample times the code divided by 4096. A monitor raises a sticky flag when the load strobe is released too soon after a write finishes, because the loaded code may then be corrupt.

Top module: `dac_pair_loader`

## Requirements
- R1: While reset is low, and just after it is released, both codes are 0, both scaled outputs are 0 and the overlap flag is 0.
- R2: When select and write are both seen low, the address picks the target. 0 is the A low byte and 1 is the A high nibble. 2 is the B low byte and 3 is the B high nibble. Address bit 1 is the channel bit.
- R3: A high-nibble write stores only bus bits 3:0. Each channel's code is {high nibble, low byte}, with the high nibble in code bits 11:8.
- R4: If select or write is high, no holding register changes.
- R5: While the load strobe stays high, holding-register writes leave both codes unchanged.
- R6: While the load strobe is low, both codes follow their holding registers and update in the same cycle. After the strobe rises, the last value is kept.
- R7: A code reflects a low load strobe on the third rising clock edge after the strobe is first sampled low, and not on the second.
- R8: The overlap flag is set when the synchronised load strobe rises fewer than MIN_GAP clocks (default 3) after a write ends, or while a write is still active. It stays set until the clear input is asserted. A new set in the same cycle wins over clear.
- R9: Each scaled output is floor(-ref × code / 4096), truncated to 16 bits. Code 0x800 gives -ref/2, code 0xFFF gives -4095/4096 of ref, and code 0 gives 0.
- R10: The four holding registers may be written in any order, and each keeps its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_data | input | 8 | Right-justified write data |
| addr | input | 2 | Holding register select |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| load_n | input | 1 | Active-low load strobe for both channels |
| ovl_clr | input | 1 | Clears the overlap flag |
| ref_in | input | 16 | Signed reference sample |
| code_a | output | 12 | Channel A output code |
| code_b | output | 12 | Channel B output code |
| out_a | output | 16 | Channel A scaled signed output |
| out_b | output | 16 | Channel B scaled signed output |
| ovl_err | output | 1 | Sticky load/write overlap flag |

## Verification
A corrupt holding register stays hidden until the next load. The bench therefore follows every batch of writes with a load and reads the codes three clocks after the strobe falls. A wrong output register shows on the code and scaled outputs on the edge where it is written, because the scaling is combinational. Counter errors in the gap monitor show as a wrong flag only at the synchronised load rise, two edges after the raw strobe goes high, so the bench places load releases on both sides of the gap limit.

// File: rtl/dpl_pkg.sv
// Package: shared widths and the holding-register address encoding.
// Assumes: two channels, each code split as an 8-bit low byte plus a 4-bit high nibble.
package dpl_pkg;
    localparam int LO_W   = 8;
    localparam int HI_W   = 4;
    localparam int CODE_W = LO_W + HI_W;
    localparam int N_CH   = 2;

    typedef enum logic [1:0] {
        SLOT_A_LO = 2'd0,
        SLOT_A_HI = 2'd1,
        SLOT_B_LO = 2'd2,
        SLOT_B_HI = 2'd3
    } slot_e;
endpackage

// File: rtl/dpl_sync.sv
// Module: multi-bit two-flop synchroniser for independent single-bit strobes.
// Assumes: each bit is an unrelated level; resets to RST_VAL (inactive).
module dpl_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Two register stages per bit to settle metastable samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d_in;
            stage2 <= stage1;
        end
    end

    assign d_out = stage2;
endmodule

// File: rtl/dpl_hold_bank.sv
// Module: four addressed holding registers (low byte + high nibble per channel).
// Assumes: wr_en is already synchronised; addr and data are stable while it is high.
module dpl_hold_bank
    import dpl_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [1:0]                    addr,
    input  logic [LO_W-1:0]               data,
    output logic [N_CH-1:0][CODE_W-1:0]   hold_code
);
    localparam int LOW_HALF_OFF = 0;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
        logic [LO_W-1:0] lo_q;
        logic [HI_W-1:0] hi_q;
        logic            hit;

        // Channel match on the upper address bit.
        assign hit = wr_en && (addr[1] == 1'(ch));

        // Store the byte or the low nibble depending on the lower address bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (hit) begin
                if (addr[0] == 1'b0) lo_q <= data;
                else                 hi_q <= data[LOW_HALF_OFF +: HI_W];
            end
        end

        assign hold_code[ch] = {hi_q, lo_q};
    end
endmodule

// File: rtl/dpl_scale.sv
// Module: digital model of the multiplying stage, out = floor(-ref * code / 2^CODE_W).
// Assumes: combinational; result truncated to REF_W bits (fits for all inputs).
module dpl_scale #(
    parameter int REF_W  = 16,
    parameter int CODE_W = 12
) (
    input  logic signed [REF_W-1:0]  ref_in,
    input  logic        [CODE_W-1:0] code,
    output logic signed [REF_W-1:0]  out_val
);
    localparam int PROD_W = REF_W + CODE_W + 2;

    logic signed [REF_W:0]    neg_ref;
    logic signed [CODE_W:0]   code_s;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;

    // Negate with one extra bit so the most negative reference is exact.
    always_comb begin
        neg_ref = -$signed({ref_in[REF_W-1], ref_in});
        code_s  = $signed({1'b0, code});
        prod    = PROD_W'(neg_ref) * PROD_W'(code_s);
        shifted = prod >>> CODE_W;
        out_val = shifted[REF_W-1:0];
    end
endmodule

// File: rtl/dpl_gap_monitor.sv
// Module: flags a load release that comes too soon after a write ends.
// Assumes: inputs are synchronised; load_rise is a one-cycle pulse.
module dpl_gap_monitor #(
    parameter int MIN_GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_active,
    input  logic load_rise,
    input  logic clr,
    output logic err
);
    localparam int           CW    = $clog2(MIN_GAP + 1);
    localparam logic [CW-1:0] GAP_L = CW'(MIN_GAP);

    logic [CW-1:0] since_wr;
    logic          too_soon;

    // Clocks since the last active write cycle, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_wr <= GAP_L;
        else if (wr_active)         since_wr <= '0;
        else if (since_wr < GAP_L)  since_wr <= since_wr + 1'b1;
    end

    assign too_soon = load_rise && (wr_active || since_wr < GAP_L);

    // Sticky flag; a fresh violation beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        err <= 1'b0;
        else if (too_soon) err <= 1'b1;
        else if (clr)      err <= 1'b0;
    end
endmodule

// File: rtl/dac_pair_loader.sv
// Module: dual-channel double-buffered code loader with digital scaling outputs.
// Assumes: addr/bus_data stable for the whole write strobe plus two clocks;
// strobes asynchronous, synchronised here; synchronous active-low reset.
module dac_pair_loader
    import dpl_pkg::*;
#(
    parameter int REF_W   = 16,
    parameter int MIN_GAP = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [7:0]              bus_data,
    input  logic [1:0]              addr,
    input  logic                    sel_n,
    input  logic                    wr_n,
    input  logic                    load_n,
    input  logic                    ovl_clr,
    input  logic signed [REF_W-1:0] ref_in,
    output logic [11:0]             code_a,
    output logic [11:0]             code_b,
    output logic signed [REF_W-1:0] out_a,
    output logic signed [REF_W-1:0] out_b,
    output logic                    ovl_err
);
    localparam int N_STB = 3;

    logic [N_STB-1:0]                 stb_s;
    logic                             sel_s_n, wr_s_n, load_s_n;
    logic                             load_prev_n;
    logic                             wr_active, load_active, load_rise;
    logic [N_CH-1:0][CODE_W-1:0]      hold_code;
    logic [N_CH-1:0][CODE_W-1:0]      code_q;
    logic signed [N_CH-1:0][REF_W-1:0] scaled;

    dpl_sync #(.W(N_STB), .RST_VAL('1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({load_n, wr_n, sel_n}),
        .d_out (stb_s)
    );

    assign sel_s_n  = stb_s[0];
    assign wr_s_n   = stb_s[1];
    assign load_s_n = stb_s[2];

    // Previous synchronised load level for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) load_prev_n <= 1'b1;
        else        load_prev_n <= load_s_n;
    end

    assign wr_active   = !sel_s_n && !wr_s_n;
    assign load_active = !load_s_n;
    assign load_rise   = load_s_n && !load_prev_n;

    dpl_hold_bank i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_active),
        .addr      (addr),
        .data      (bus_data),
        .hold_code (hold_code)
    );

    // Output registers track the holding registers while load is active.
    always_ff @(posedge clk) begin
        if (!rst_n)           code_q <= '0;
        else if (load_active) code_q <= hold_code;
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_scale
        dpl_scale #(.REF_W(REF_W), .CODE_W(CODE_W)) i_scale (
            .ref_in  (ref_in),
            .code    (code_q[ch]),
            .out_val (scaled[ch])
        );
    end

    dpl_gap_monitor #(.MIN_GAP(MIN_GAP)) i_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_active (wr_active),
        .load_rise (load_rise),
        .clr       (ovl_clr),
        .err       (ovl_err)
    );

    assign code_a = code_q[0];
    assign code_b = code_q[1];
    assign out_a  = scaled[0];
    assign out_b  = scaled[1];
endmodule

// File: rtl/dpl_checker.sv
// Module: port-level properties for dac_pair_loader, attached by bind.
// Assumes: synchronous active-low reset; strobe synchroniser depth of two.
module dpl_checker #(
    parameter int REF_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    load_n,
    input logic                    ovl_clr,
    input logic signed [REF_W-1:0] ref_in,
    input logic [11:0]             code_a,
    input logic [11:0]             code_b,
    input logic signed [REF_W-1:0] out_a,
    input logic signed [REF_W-1:0] out_b,
    input logic                    ovl_err
);
    AST_CODES_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n && $past(load_n) && $past(load_n, 2) && $past(load_n, 3))
        |-> ($stable(code_a) && $stable(code_b))); // R5

    AST_ZERO_CODE_A: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a == 12'd0) |-> (out_a == '0)); // R9

    AST_ZERO_CODE_B: assert property (@(posedge clk) disable iff (!rst_n)
        (code_b == 12'd0) |-> (out_b == '0)); // R9

    AST_SIGN_A: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a != 12'd0 && ref_in > 0) |-> (out_a < 0)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_err && !ovl_clr) |=> ovl_err); // R8

    AST_FLAG_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovl_err) |-> $past(load_n, 2)); // R8
endmodule

bind dac_pair_loader dpl_checker #(.REF_W(REF_W)) i_dpl_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n  (load_n),
    .ovl_clr (ovl_clr),
    .ref_in  (ref_in),
    .code_a  (code_a),
    .code_b  (code_b),
    .out_a   (out_a),
    .out_b   (out_b),
    .ovl_err (ovl_err)
);

// File: tb/test_dac_pair_loader.sv
// Bench: directed scenarios for dac_pair_loader, one task per scenario.
module test_dac_pair_loader;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_data = '0;
    logic [1:0]        addr = '0;
    logic              sel_n = 1'b1;
    logic              wr_n = 1'b1;
    logic              load_n = 1'b1;
    logic              ovl_clr = 1'b0;
    logic signed [15:0] ref_in = '0;
    logic [11:0]       code_a, code_b;
    logic signed [15:0] out_a, out_b;
    logic              ovl_err;

    int n_checks = 0;
    int n_errs   = 0;

    always #2 clk = ~clk;

    dac_pair_loader i_dac_pair_loader (
        .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .addr(addr),
        .sel_n(sel_n), .wr_n(wr_n), .load_n(load_n), .ovl_clr(ovl_clr),
        .ref_in(ref_in), .code_a(code_a), .code_b(code_b),
        .out_a(out_a), .out_b(out_b), .ovl_err(ovl_err)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model_out(input longint r, input longint c);
        longint p;
        logic [15:0] t;
        p = (-r) * c;
        p = p >>> 12;
        t = p[15:0];
        return longint'($signed(t));
    endfunction

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d,
                            input logic s_n = 1'b0, input logic w_n = 1'b0);
        @(negedge clk);
        addr = a; bus_data = d; sel_n = s_n; wr_n = w_n;
        waitn(4);
        sel_n = 1'b1; wr_n = 1'b1;
        waitn(4);
    endtask

    task automatic do_load();
        @(negedge clk);
        load_n = 1'b0;
        waitn(4);
        load_n = 1'b1;
        waitn(6);
    endtask

    task automatic t_reset();
        waitn(2);
        chk("R1 code_a", code_a, 0);
        chk("R1 code_b", code_b, 0);
        chk("R1 out_a", out_a, 0);
        chk("R1 flag", ovl_err, 0);
        rst_n = 1'b1;
        waitn(3);
        chk("R1 code_b after release", code_b, 0);
        chk("R1 out_b after release", out_b, 0);
    endtask

    task automatic t_decode();
        do_write(2'd0, 8'h34);
        do_write(2'd1, 8'hF2);   // R3: only nibble 2 kept
        do_write(2'd2, 8'hCD);
        do_write(2'd3, 8'h0B);
        do_load();
        chk("R2/R3 code_a", code_a, 12'h234);
        chk("R2/R3 code_b", code_b, 12'hBCD);
    endtask

    task automatic t_any_order();
        do_write(2'd3, 8'h05);
        do_write(2'd0, 8'h9A);
        do_write(2'd2, 8'h11);
        do_write(2'd1, 8'h0E);
        do_load();
        chk("R10 code_a", code_a, 12'hE9A);
        chk("R10 code_b", code_b, 12'h511);
    endtask

    task automatic t_ignored();
        @(negedge clk);
        load_n = 1'b0;
        waitn(4);
        do_write(2'd0, 8'h00, 1'b1, 1'b0);
        chk("R4 sel high", code_a, 12'hE9A);
        do_write(2'd2, 8'h00, 1'b0, 1'b1);
        chk("R4 wr high", code_b, 12'h511);
        load_n = 1'b1;
        waitn(6);
    endtask

    task automatic t_frozen_then_joint();
        do_write(2'd0, 8'h00);
        do_write(2'd1, 8'h08);
        do_write(2'd2, 8'hFF);
        do_write(2'd3, 8'h0F);
        chk("R5 code_a frozen", code_a, 12'hE9A);
        chk("R5 code_b frozen", code_b, 12'h511);
        do_load();
        chk("R6 code_a", code_a, 12'h800);
        chk("R6 code_b", code_b, 12'hFFF);
    endtask

    task automatic t_latency_follow();
        do_write(2'd0, 8'h55);   // A becomes 0x855 in holding
        do_write(2'd2, 8'h66);   // B becomes 0xF66
        @(negedge clk);
        load_n = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 not yet A", code_a, 12'h800);
        chk("R7 not yet B", code_b, 12'hFFF);
        @(posedge clk); #1;
        chk("R7/R6 A updated", code_a, 12'h855);
        chk("R7/R6 B same cycle", code_b, 12'hF66);
        // Still low: a new write is followed through (R6 transparency)
        do_write(2'd0, 8'h77);
        chk("R6 follow while low", code_a, 12'h877);
        load_n = 1'b1;
        waitn(6);
        do_write(2'd0, 8'h01);
        chk("R6 kept after rise", code_a, 12'h877);
        do_load();
    endtask

    task automatic t_overlap();
        chk("R8 flag clean", ovl_err, 0);
        @(negedge clk);
        load_n = 1'b0; addr = 2'd0; bus_data = 8'h10; sel_n = 1'b0; wr_n = 1'b0;
        waitn(4);
        load_n = 1'b1; sel_n = 1'b1; wr_n = 1'b1;
        waitn(5);
        chk("R8 set on overlap", ovl_err, 1);
        waitn(8);
        chk("R8 sticky", ovl_err, 1);
        ovl_clr = 1'b1;
        waitn(1);
        ovl_clr = 1'b0;
        waitn(1);
        chk("R8 cleared", ovl_err, 0);
        @(negedge clk);
        load_n = 1'b0; sel_n = 1'b0; wr_n = 1'b0;
        waitn(4);
        sel_n = 1'b1; wr_n = 1'b1;
        waitn(6);
        load_n = 1'b1;
        waitn(6);
        chk("R8 no flag with gap", ovl_err, 0);
    endtask

    task automatic t_scale();
        do_write(2'd0, 8'h00); do_write(2'd1, 8'h08);
        do_write(2'd2, 8'hFF); do_write(2'd3, 8'h0F);
        do_load();
        ref_in = 16'sd4096; #1;
        chk("R9 half", out_a, -2048);
        chk("R9 full", out_b, -4095);
        ref_in = -16'sd32768; #1;
        chk("R9 min ref A", out_a, model_out(-32768, 12'h800));
        chk("R9 min ref B", out_b, model_out(-32768, 12'hFFF));
        ref_in = 16'sd1; #1;
        chk("R9 floor", out_a, model_out(1, 12'h800));
        ref_in = 16'sd12345; #1;
        chk("R9 generic B", out_b, model_out(12345, 12'hFFF));
        do_write(2'd0, 8'h00); do_write(2'd1, 8'h00);
        do_load();
        chk("R9 zero code", out_a, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_any_order();
        t_ignored();
        t_frozen_then_joint();
        t_latency_follow();
        t_overlap();
        t_scale();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule